// File: doc/BRIEF.md
# Segmented Address Translator

This block turns a logical offset and a requested byte count into a physical address and a granted byte count. It supports two address spaces, data and instruction, and each space has its own bank of 16-bit map registers. The logical window is cut into equal blocks, and each block has one map register. The register's space code picks the target memory: unified, instruction or internal data. The register also supplies a segment number. A data map register can also send its block to I/O space. A granted length never runs past the end of a block.

A request with a data/instruction select is taken in one cycle. The result comes back on the next clock edge together with a response strobe. An address that cannot be mapped returns an error with a zero length. The map registers are loaded through a write port that decodes two small address windows. The physical bases of the three memories are parameters, because a downstream router decodes them.

Top module: `seg_xlate`

## Requirements
- R1: The map register index is the logical offset divided by BLK_BYTES (default 16384), and the in-block offset is the remainder. An offset of BLK_BYTES × NMAP (default 4 registers, so 0x10000) or more yields an error.
- R2: When in-block offset + requested length exceeds BLK_BYTES, the granted length is BLK_BYTES − in-block offset. Otherwise it equals the request. A request that ends exactly on the block end is not clipped.
- R3: Data mapping with map bit 15 clear uses bits [13:12] as the space code and bits [9:0] as the segment S.
  - 00 gives UNI_BASE (0x0000_0000) + S×BLK_BYTES + offset.
  - 01 gives INS_BASE (0x0100_0000) + S×BLK_BYTES + offset.
  - 10 gives DAT_BASE (0x0200_0000) + S×0x10000 + index×BLK_BYTES + offset.
  - 11 is an error.
- R4: Data mapping with map bit 15 set is I/O space. Let k = (in-block offset >> 12) mod 4. The I/O number is map nibble [15−4k : 12−4k], so k=0 takes the most significant nibble. The physical address is DAT_BASE + I/O number×0x10000 + 0xC000 + offset.
- R5: Instruction mapping uses bits [13:12] as the space code and bits [6:0] as the segment S.
  - 00 gives UNI_BASE + S×0x20000 + offset.
  - 01 gives INS_BASE + index×BLK_BYTES + offset.
  - 10 is an error.
- R6: Instruction code 11 is a test mode. The address is INS_BASE + (offset mod 0x800). The granted length is further clipped so it does not cross a 0x800 boundary.
- R7: A write with cfg_we sets instruction map register i at cfg_addr 0xFF00+2i and data map register i at 0xFF08+2i. A write to any other address, including an odd one, changes no register.
- R8: resp_vld is high in exactly the cycle after a cycle with req_vld high. The response outputs hold their values between responses.
- R9: A response with resp_err high carries resp_len = 0 and resp_phys = 0.
- R10: After reset, resp_vld, resp_err, resp_phys and resp_len are zero, and all map registers are zero.
- R11: A request in the same cycle as a map register write is translated with the register's old value. The new value applies from the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_vld | input | 1 | Translation request strobe |
| req_insn | input | 1 | 1 = instruction space, 0 = data space |
| req_off | input | LOFF_W | Logical offset |
| req_len | input | LEN_W | Requested byte count |
| cfg_we | input | 1 | Map register write enable |
| cfg_addr | input | 16 | Map register write address |
| cfg_wdata | input | 16 | Map register write data |
| resp_vld | output | 1 | Response strobe |
| resp_err | output | 1 | Translation error |
| resp_phys | output | 32 | Physical address |
| resp_len | output | LEN_W | Granted byte count |

## Verification
Two functions can fall in the same cycle: a map register write and a translation request that reads that same register. The bench provokes this by rewriting data map register 0 in the cycle a data request to block 0 is presented. It checks that the response still reflects the old I/O mapping, and that the next request sees the new unified mapping.

// File: rtl/seg_xlate_pkg.sv
// Shared types and encodings of the segmented address translator.
// Assumes 16-bit map registers and a 32-bit physical address.
package seg_xlate_pkg;
    typedef logic [15:0] map_word_t;
    typedef logic [31:0] paddr_t;

    // Space codes held in map bits [13:12]
    localparam logic [1:0] SPC_UNI  = 2'b00;
    localparam logic [1:0] SPC_INS  = 2'b01;
    localparam logic [1:0] SPC_DAT  = 2'b10;
    localparam logic [1:0] SPC_TEST = 2'b11;

    // Data map bit that redirects a block to I/O space
    localparam int IO_FLAG_BIT = 15;

    // I/O window inside each I/O segment, and the test-mode span
    localparam logic [31:0] IO_WIN   = 32'h0000_C000;
    localparam logic [31:0] IO_STEP  = 32'h0001_0000;
    localparam logic [31:0] TEST_SPAN = 32'h0000_0800;
endpackage

// File: rtl/seg_map_regs.sv
// Bank of instruction and data map registers with an address-decoded
// write port. Assumes both bases are even; odd or unmatched addresses
// are ignored.
module seg_map_regs
    import seg_xlate_pkg::*;
#(
    parameter int          NMAP      = 4,
    parameter logic [15:0] IMAP_BASE = 16'hFF00,
    parameter logic [15:0] DMAP_BASE = 16'hFF08
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic [15:0]               addr,
    input  logic [15:0]               wdata,
    output logic [NMAP-1:0][15:0]     imap,
    output logic [NMAP-1:0][15:0]     dmap
);
    for (genvar i = 0; i < NMAP; i++) begin : g_reg
        localparam logic [15:0] IA = IMAP_BASE + 16'(2 * i);
        localparam logic [15:0] DA = DMAP_BASE + 16'(2 * i);

        // Instruction map register i: cleared on reset, loaded on match
        always_ff @(posedge clk) begin
            if (!rst_n)                  imap[i] <= '0;
            else if (we && addr == IA)   imap[i] <= wdata;
        end

        // Data map register i: cleared on reset, loaded on match
        always_ff @(posedge clk) begin
            if (!rst_n)                  dmap[i] <= '0;
            else if (we && addr == DA)   dmap[i] <= wdata;
        end
    end
endmodule

// File: rtl/seg_xlate_core.sv
// Combinational translation of one logical offset and length through
// the map registers. Assumes BLK_BYTES is a power of two.
module seg_xlate_core
    import seg_xlate_pkg::*;
#(
    parameter int          BLK_BYTES = 16384,
    parameter int          NMAP      = 4,
    parameter int          LOFF_W    = 24,
    parameter int          LEN_W     = 16,
    parameter logic [31:0] UNI_BASE  = 32'h0000_0000,
    parameter logic [31:0] INS_BASE  = 32'h0100_0000,
    parameter logic [31:0] DAT_BASE  = 32'h0200_0000
) (
    input  logic                  insn,
    input  logic [LOFF_W-1:0]     off,
    input  logic [LEN_W-1:0]      len,
    input  logic [NMAP-1:0][15:0] imap,
    input  logic [NMAP-1:0][15:0] dmap,
    output logic                  err,
    output logic [31:0]           phys,
    output logic [LEN_W-1:0]      glen
);
    localparam int OFF_W = $clog2(BLK_BYTES);
    localparam int IDX_W = (NMAP > 1) ? $clog2(NMAP) : 1;
    localparam logic [31:0] BLK32 = 32'(BLK_BYTES);
    localparam logic [31:0] LIMIT = 32'(BLK_BYTES) * 32'(NMAP);

    logic [31:0]    off_full, boff, len32, rem, blen, idx32, tlen;
    logic [IDX_W-1:0] idx;
    map_word_t      map;
    logic [1:0]     spc;
    logic [3:0]     io_nib;
    logic           in_range;

    // Split the logical offset into register index and in-block offset
    always_comb begin
        off_full = 32'(off);
        in_range = off_full < LIMIT;
        boff     = off_full & (BLK32 - 32'd1);
        idx32    = off_full >> OFF_W;
        idx      = in_range ? IDX_W'(idx32) : '0;
        map      = insn ? imap[idx] : dmap[idx];
        spc      = map[13:12];
    end

    // Granted length clipped at the block end, and at the test span
    always_comb begin
        len32 = 32'(len);
        rem   = BLK32 - boff;
        blen  = (len32 > rem) ? rem : len32;
        tlen  = TEST_SPAN - (boff & (TEST_SPAN - 32'd1));
        if (blen > tlen) tlen = tlen;
        else             tlen = blen;
    end

    // I/O nibble: most significant nibble for the lowest 4 KiB slice
    always_comb begin
        case (boff[13:12])
            2'd0:    io_nib = map[15:12];
            2'd1:    io_nib = map[11:8];
            2'd2:    io_nib = map[7:4];
            default: io_nib = map[3:0];
        endcase
    end

    // Compose the physical address and flag untranslatable requests
    always_comb begin
        err  = 1'b0;
        phys = '0;
        glen = LEN_W'(blen);
        if (!in_range) begin
            err = 1'b1;
        end else if (insn) begin
            case (spc)
                SPC_UNI:  phys = UNI_BASE + (32'(map[6:0]) << 17) + boff;
                SPC_INS:  phys = INS_BASE + idx32 * BLK32 + boff;
                SPC_TEST: begin
                    phys = INS_BASE + (boff & (TEST_SPAN - 32'd1));
                    glen = LEN_W'(tlen);
                end
                default:  err = 1'b1;
            endcase
        end else if (map[IO_FLAG_BIT]) begin
            phys = DAT_BASE + 32'(io_nib) * IO_STEP + IO_WIN + boff;
        end else begin
            case (spc)
                SPC_UNI:  phys = UNI_BASE + 32'(map[9:0]) * BLK32 + boff;
                SPC_INS:  phys = INS_BASE + 32'(map[9:0]) * BLK32 + boff;
                SPC_DAT:  phys = DAT_BASE + (32'(map[9:0]) << 16)
                                 + idx32 * BLK32 + boff;
                default:  err = 1'b1;
            endcase
        end
        if (err) begin
            phys = '0;
            glen = '0;
        end
    end
endmodule

// File: rtl/seg_xlate.sv
// Top of the segmented address translator: map register bank, a
// combinational translation stage and a one-cycle response register.
// Assumes requests and map writes are synchronous to clk.
module seg_xlate
    import seg_xlate_pkg::*;
#(
    parameter int          BLK_BYTES = 16384,
    parameter int          NMAP      = 4,
    parameter int          LOFF_W    = 24,
    parameter int          LEN_W     = 16,
    parameter logic [31:0] UNI_BASE  = 32'h0000_0000,
    parameter logic [31:0] INS_BASE  = 32'h0100_0000,
    parameter logic [31:0] DAT_BASE  = 32'h0200_0000,
    parameter logic [15:0] IMAP_BASE = 16'hFF00,
    parameter logic [15:0] DMAP_BASE = 16'hFF08
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_vld,
    input  logic              req_insn,
    input  logic [LOFF_W-1:0] req_off,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              cfg_we,
    input  logic [15:0]       cfg_addr,
    input  logic [15:0]       cfg_wdata,
    output logic              resp_vld,
    output logic              resp_err,
    output logic [31:0]       resp_phys,
    output logic [LEN_W-1:0]  resp_len
);
    logic [NMAP-1:0][15:0] imap, dmap;
    logic                  x_err;
    logic [31:0]           x_phys;
    logic [LEN_W-1:0]      x_len;

    seg_map_regs #(
        .NMAP(NMAP), .IMAP_BASE(IMAP_BASE), .DMAP_BASE(DMAP_BASE)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
        .wdata(cfg_wdata), .imap(imap), .dmap(dmap)
    );

    seg_xlate_core #(
        .BLK_BYTES(BLK_BYTES), .NMAP(NMAP), .LOFF_W(LOFF_W), .LEN_W(LEN_W),
        .UNI_BASE(UNI_BASE), .INS_BASE(INS_BASE), .DAT_BASE(DAT_BASE)
    ) u_core (
        .insn(req_insn), .off(req_off), .len(req_len),
        .imap(imap), .dmap(dmap),
        .err(x_err), .phys(x_phys), .glen(x_len)
    );

    // Response strobe: one cycle after each request
    always_ff @(posedge clk) begin
        if (!rst_n) resp_vld <= 1'b0;
        else        resp_vld <= req_vld;
    end

    // Response data: captured on a request, held otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_err  <= 1'b0;
            resp_phys <= '0;
            resp_len  <= '0;
        end else if (req_vld) begin
            resp_err  <= x_err;
            resp_phys <= x_phys;
            resp_len  <= x_len;
        end
    end
endmodule

// File: rtl/seg_xlate_chk.sv
// Protocol and result checks for seg_xlate, bound to every instance.
module seg_xlate_chk #(
    parameter int BLK_BYTES = 16384,
    parameter int NMAP      = 4,
    parameter int LOFF_W    = 24,
    parameter int LEN_W     = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_vld,
    input logic [LOFF_W-1:0] req_off,
    input logic [LEN_W-1:0]  req_len,
    input logic              resp_vld,
    input logic              resp_err,
    input logic [31:0]       resp_phys,
    input logic [LEN_W-1:0]  resp_len
);
    localparam logic [31:0] LIMIT = 32'(BLK_BYTES) * 32'(NMAP);

    // R8
    resp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld |=> resp_vld);
    // R8
    no_spurious_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_vld |=> !resp_vld);
    // R8
    resp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_vld |=> ($stable(resp_phys) && $stable(resp_len)));
    // R9
    err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_vld && resp_err) |-> (resp_len == '0 && resp_phys == '0));
    // R1
    range_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && 32'(req_off) >= LIMIT) |=> resp_err);
    // R2
    len_no_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld |=> (resp_len <= $past(req_len)));
    // R2
    len_in_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_vld |-> (32'(resp_len) <= 32'(BLK_BYTES)));
endmodule

bind seg_xlate seg_xlate_chk #(
    .BLK_BYTES(BLK_BYTES), .NMAP(NMAP), .LOFF_W(LOFF_W), .LEN_W(LEN_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_off(req_off),
    .req_len(req_len), .resp_vld(resp_vld), .resp_err(resp_err),
    .resp_phys(resp_phys), .resp_len(resp_len)
);

// File: tb/seg_xlate_tb.sv
module seg_xlate_tb;
    typedef struct packed {
        logic [3:0]  req;
        logic        insn;
        logic [23:0] off;
        logic [15:0] len;
        logic        err;
        logic [31:0] phys;
        logic [15:0] glen;
    } vec_t;

    // Maps loaded first: imap = 0005,1000,2000,3000; dmap = 0003,1002,2001,3000
    localparam vec_t VECS [0:12] = '{
        '{4'd3, 1'b0, 24'h000010, 16'd4,     1'b0, 32'h0000_C010, 16'd4},    // R3 uni
        '{4'd3, 1'b0, 24'h004020, 16'd8,     1'b0, 32'h0100_8020, 16'd8},    // R3 ins
        '{4'd3, 1'b0, 24'h008100, 16'd2,     1'b0, 32'h0201_8100, 16'd2},    // R3 dat
        '{4'd3, 1'b0, 24'h00C000, 16'd2,     1'b1, 32'h0,         16'd0},    // R3 code 11
        '{4'd1, 1'b0, 24'h010000, 16'd2,     1'b1, 32'h0,         16'd0},    // R1 range
        '{4'd2, 1'b0, 24'h003FFE, 16'd8,     1'b0, 32'h0000_FFFE, 16'd2},    // R2 clip
        '{4'd2, 1'b0, 24'h003FF8, 16'd8,     1'b0, 32'h0000_FFF8, 16'd8},    // R2 exact
        '{4'd5, 1'b1, 24'h000100, 16'd4,     1'b0, 32'h000A_0100, 16'd4},    // R5 uni
        '{4'd5, 1'b1, 24'h004044, 16'd6,     1'b0, 32'h0100_4044, 16'd6},    // R5 ins
        '{4'd5, 1'b1, 24'h008000, 16'd2,     1'b1, 32'h0,         16'd0},    // R5 code 10
        '{4'd6, 1'b1, 24'h00CFF0, 16'h40,    1'b0, 32'h0100_07F0, 16'h10},   // R6 test
        '{4'd1, 1'b1, 24'h010000, 16'd2,     1'b1, 32'h0,         16'd0},    // R1 range
        '{4'd2, 1'b1, 24'h007FFC, 16'h10,    1'b0, 32'h0100_7FFC, 16'd4}     // R2 clip
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_vld = 1'b0, req_insn = 1'b0, cfg_we = 1'b0;
    logic [23:0] req_off = '0;
    logic [15:0] req_len = '0, cfg_addr = '0, cfg_wdata = '0;
    logic resp_vld, resp_err;
    logic [31:0] resp_phys;
    logic [15:0] resp_len;
    int n_run = 0, n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    seg_xlate u_dut (
        .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_insn(req_insn),
        .req_off(req_off), .req_len(req_len), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .resp_vld(resp_vld),
        .resp_err(resp_err), .resp_phys(resp_phys), .resp_len(resp_len)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Presents one request and leaves the response sampled at the next negedge
    task automatic xlate(input logic ins, input logic [23:0] o, input logic [15:0] l);
        @(negedge clk);
        req_vld = 1'b1; req_insn = ins; req_off = o; req_len = l;
        @(negedge clk);
        req_vld = 1'b0;
    endtask

    task automatic expect_resp(input string tag, input logic e, input logic [31:0] p,
                               input logic [15:0] g);
        check({tag, " vld"},  32'(resp_vld), 32'd1);
        check({tag, " err"},  32'(resp_err), 32'(e));
        check({tag, " phys"}, resp_phys, p);
        check({tag, " len"},  32'(resp_len), 32'(g));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state of the outputs
        check("R10 vld",  32'(resp_vld), 32'd0);
        check("R10 err",  32'(resp_err), 32'd0);
        check("R10 phys", resp_phys, 32'd0);
        rst_n = 1'b1;
        // R10: map registers reset to zero -> data block 0 is unified seg 0
        xlate(1'b0, 24'h000123, 16'd4);
        expect_resp("R10 map", 1'b0, 32'h0000_0123, 16'd4);

        // R7: load all map registers through the write port
        wr(16'hFF00, 16'h0005); wr(16'hFF02, 16'h1000);
        wr(16'hFF04, 16'h2000); wr(16'hFF06, 16'h3000);
        wr(16'hFF08, 16'h0003); wr(16'hFF0A, 16'h1002);
        wr(16'hFF0C, 16'h2001); wr(16'hFF0E, 16'h3000);

        foreach (VECS[i]) begin
            xlate(VECS[i].insn, VECS[i].off, VECS[i].len);
            expect_resp($sformatf("R%0d vec%0d", VECS[i].req, i),
                        VECS[i].err, VECS[i].phys, VECS[i].glen);
        end

        // R8: no request -> no response strobe, outputs held
        @(negedge clk);
        check("R8 idle vld",  32'(resp_vld), 32'd0);
        check("R8 hold len",  32'(resp_len), 32'd4);

        // R7: writes to an odd and to an unmapped address are ignored
        wr(16'hFF09, 16'h0007);
        wr(16'hFF10, 16'h0007);
        xlate(1'b0, 24'h000010, 16'd4);
        expect_resp("R7 ignored", 1'b0, 32'h0000_C010, 16'd4);

        // R4: I/O space via data map 0 = 0xC35A (bit 15 set)
        wr(16'hFF08, 16'hC35A);
        xlate(1'b0, 24'h000010, 16'd4);
        expect_resp("R4 nib0", 1'b0, 32'h020C_C010, 16'd4);
        xlate(1'b0, 24'h001010, 16'd4);
        expect_resp("R4 nib1", 1'b0, 32'h0203_D010, 16'd4);
        xlate(1'b0, 24'h003020, 16'd4);
        expect_resp("R4 nib3", 1'b0, 32'h020A_F020, 16'd4);

        // R11: write and request together -> old mapping, then new one
        @(negedge clk);
        req_vld = 1'b1; req_insn = 1'b0; req_off = 24'h000010; req_len = 16'd4;
        cfg_we = 1'b1; cfg_addr = 16'hFF08; cfg_wdata = 16'h0007;
        @(negedge clk);
        req_vld = 1'b0; cfg_we = 1'b0;
        expect_resp("R11 old", 1'b0, 32'h020C_C010, 16'd4);
        xlate(1'b0, 24'h000010, 16'd4);
        expect_resp("R11 new", 1'b0, 32'h0001_C010, 16'd4);

        // R9: error response zeroes address and length after a good one
        xlate(1'b1, 24'h00A000, 16'd8);
        expect_resp("R9 err", 1'b1, 32'h0, 16'd0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule